// File: doc/BRIEF.md
# Power Management Configuration and SCI Logic

This block is the configuration side of a power-management PCI function. Software writes it through a dword-indexed port with four byte enables. It holds two I/O base registers, one for the power-management register window and one for the SMBus host window, each with its own enable byte. For each window it reports a decoded base address and an enable flag. The window outputs are re-sampled only when software writes the enable byte for that window. A write to a base register alone leaves the live window where it was.

It also holds a 16-bit event status register and a 16-bit event enable register. Event sources pulse the status bits. Software clears status bits by writing ones. The SCI interrupt is raised when any of four event bits is both pending and enabled, and only while the interrupt-pin configuration byte is nonzero. A run request is sent to an external PM timer while the timer event is enabled and its status bit is still clear.

Top module: `pm_cfg_sci_top`

## Requirements
- R1: Dword index 0x12 (byte address 0x48) holds the PM base. Any write with byte enable 0 or 1 set merges the enabled bytes of bits 15:0. The stored value keeps only bits 15:7, bits 6:1 read 0, bit 0 reads 1, and bits 31:16 read 0.
- R2: Dword index 0x24 (byte address 0x90) holds the SMBus base. It is written the same way as R1. The stored value keeps bits 15:4, bits 3:1 read 0, bit 0 reads 1, and bits 31:16 read 0.
- R3: A write to dword index 0x10 with byte enable 1 (byte 0x41) stores that byte, which reads back at bits 15:8 of the dword. On the next cycle, `pm_win_en_o` equals bit 7 of the written byte and `pm_win_base_o` equals the stored PM base with bit 0 cleared. No other write changes either output.
- R4: A write to dword index 0x34 with byte enable 2 (byte 0xD2) stores only the low 4 bits of that byte, which read back at bits 19:16 of the dword. On the next cycle, `smb_win_en_o` equals bit 0 of the stored value and `smb_win_base_o` equals the stored SMBus base with bit 0 cleared. No other write changes either output.
- R5: After reset, both base dwords read 0x00000001. The enable bytes, both window outputs, both event registers, `sci_o` and `tmr_run_o` are all 0. The interrupt-pin byte holds `INT_PIN_RST`.
- R6: A status write (`pm1_wr_i` high, `pm1_sel_i` = 0) clears each status bit where the write data holds a one. A one on `evt_i` sets the matching bit. When an event and a clear hit the same bit in the same cycle, the event wins.
- R7: An enable write (`pm1_wr_i` high, `pm1_sel_i` = 1) loads all 16 enable bits. A status write leaves the enable register unchanged, and an enable write leaves the status register unchanged.
- R8: `sci_o` is high exactly when the interrupt-pin byte (dword index 0x0F, byte enable 1, bits 15:8) is nonzero and one of status bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC) is set together with its enable bit. No other bit affects `sci_o`.
- R9: `tmr_run_o` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R10: Byte lanes that are not enabled keep their old contents. A write to dword index 0x10 or 0x34 that does not enable the enable-byte lane does not change the window outputs. Dword indices that no register uses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 6 | Configuration dword index (byte address / 4) |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_idx_i`, combinational |
| pm1_wr_i | input | 1 | Event register write strobe |
| pm1_sel_i | input | 1 | 0 selects status (write one to clear), 1 selects enable |
| pm1_wdata_i | input | 16 | Event register write data |
| evt_i | input | 16 | One-cycle event pulses, one per status bit |
| pm1_sts_o | output | 16 | Event status register |
| pm1_en_o | output | 16 | Event enable register |
| pm_win_base_o | output | 16 | Live PM window base |
| pm_win_en_o | output | 1 | PM window enabled |
| smb_win_base_o | output | 16 | Live SMBus window base |
| smb_win_en_o | output | 1 | SMBus window enabled |
| sci_o | output | 1 | SCI interrupt level |
| tmr_run_o | output | 1 | Run request to the PM timer |

## Verification
The hardest case to reach from the ports is a live window whose base differs from the programmed base register. Getting there takes a base write after the last enable-byte write and then a check that the outputs did not move. The random stimulus aims most writes at the few indices in use, with random byte enables, so this split state comes up often. A second hard case is an event and a clear landing on the same status bit in the same cycle. The bench forces it in a directed step, and the random steps mix event pulses with status writes so that it also appears at random.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;
  localparam int unsigned CFG_IW   = 6;
  localparam int unsigned EVT_W    = 16;

  localparam logic [CFG_IW-1:0] IDX_INTPIN = 6'h0F;
  localparam logic [CFG_IW-1:0] IDX_PMEN   = 6'h10;
  localparam logic [CFG_IW-1:0] IDX_PMBASE = 6'h12;
  localparam logic [CFG_IW-1:0] IDX_SMBASE = 6'h24;
  localparam logic [CFG_IW-1:0] IDX_SMEN   = 6'h34;

  localparam int unsigned PM_ALIGN  = 7;
  localparam int unsigned SMB_ALIGN = 4;
  localparam int unsigned PM_EN_W   = 8;
  localparam int unsigned SMB_EN_W  = 4;
  localparam int unsigned PM_EN_BIT = 7;
  localparam int unsigned SMB_EN_BIT = 0;

  localparam int unsigned TMR_BIT = 0;
  localparam logic [EVT_W-1:0] SCI_MASK = 16'h0521;
endpackage

// File: rtl/pm_base_win.sv
module pm_base_win #(
  parameter int unsigned ALIGN  = 7,
  parameter int unsigned EN_W   = 8,
  parameter int unsigned EN_BIT = 7,
  localparam int unsigned AW    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            base_wr_i,
  input  logic [1:0]      base_be_i,
  input  logic [AW-1:0]   base_wdata_i,
  input  logic            en_wr_i,
  input  logic [EN_W-1:0] en_wdata_i,
  output logic [AW-1:0]   base_rd_o,
  output logic [EN_W-1:0] en_rd_o,
  output logic [AW-1:0]   win_base_o,
  output logic            win_en_o
);
  localparam int unsigned KW = AW - ALIGN;

  logic [KW-1:0]   base_q;
  logic [EN_W-1:0] en_q;
  logic [AW-1:0]   win_base_q;
  logic            win_en_q;
  logic [AW-1:0]   merged;
  logic [AW-1:0]   base_full;

  assign base_full = {base_q, {ALIGN{1'b0}}};

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign merged[b*8 +: 8] = base_be_i[b] ? base_wdata_i[b*8 +: 8] : base_full[b*8 +: 8];
  end

  logic unused_low_bits;
  assign unused_low_bits = ^merged[ALIGN-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      en_q       <= '0;
      win_base_q <= '0;
      win_en_q   <= 1'b0;
    end else begin
      if (base_wr_i) base_q <= merged[AW-1:ALIGN];
      if (en_wr_i) begin
        en_q       <= en_wdata_i;
        // window follows the enable-byte write only
        win_en_q   <= en_wdata_i[EN_BIT];
        win_base_q <= base_full;
      end
    end
  end

  assign base_rd_o  = base_full | {{(AW-1){1'b0}}, 1'b1};
  assign en_rd_o    = en_q;
  assign win_base_o = win_base_q;
  assign win_en_o   = win_en_q;

  // R3 / R4: window outputs move only on an enable-byte write
  assert_win_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> ($stable(win_en_q) && $stable(win_base_q)));
  assert_win_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> (win_en_q == en_q[EN_BIT]));
  // R1 / R2: base readback has no bits below the alignment except bit 0
  assert_base_align_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> (base_rd_o[ALIGN-1:0] == {{(ALIGN-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/pm1_event_regs.sv
module pm1_event_regs
  import pm_cfg_pkg::*;
#(
  parameter int unsigned W = EVT_W,
  parameter logic [W-1:0] MASK = SCI_MASK,
  parameter int unsigned TBIT = TMR_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_sts_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] evt_i,
  input  logic         pin_nz_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] en_o,
  output logic         sci_o,
  output logic         tmr_run_o
);
  logic [W-1:0] sts_q, en_q, clr;

  assign clr = wr_sts_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | evt_i;
      if (wr_en_i) en_q <= wdata_i;
    end
  end

  assign sts_o     = sts_q;
  assign en_o      = en_q;
  assign sci_o     = pin_nz_i && ((sts_q & en_q & MASK) != '0);
  assign tmr_run_o = en_q[TBIT] && !sts_q[TBIT];

  assert_evt_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));
  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts_i && evt_i == '0) |=> (sts_q == ($past(sts_q) & ~$past(wdata_i))));
  assert_en_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q));
  assert_sci_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_nz_i |-> !sci_o);
  assert_tmr_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[TBIT]) |-> !tmr_run_o);
endmodule

// File: rtl/pm_cfg_sci_top.sv
module pm_cfg_sci_top
  import pm_cfg_pkg::*;
#(
  parameter logic [7:0] INT_PIN_RST = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_IW-1:0] cfg_idx_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              pm1_wr_i,
  input  logic              pm1_sel_i,
  input  logic [EVT_W-1:0]  pm1_wdata_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [EVT_W-1:0]  pm1_sts_o,
  output logic [EVT_W-1:0]  pm1_en_o,
  output logic [15:0]       pm_win_base_o,
  output logic              pm_win_en_o,
  output logic [15:0]       smb_win_base_o,
  output logic              smb_win_en_o,
  output logic              sci_o,
  output logic              tmr_run_o
);
  logic pm_base_wr, pm_en_wr, smb_base_wr, smb_en_wr, pin_wr;
  logic [15:0] pm_base_rd, smb_base_rd;
  logic [PM_EN_W-1:0]  pm_en_rd;
  logic [SMB_EN_W-1:0] smb_en_rd;
  logic [7:0] pin_q;

  assign pm_base_wr  = cfg_wr_i && cfg_idx_i == IDX_PMBASE && (cfg_be_i[1:0] != 2'b00);
  assign smb_base_wr = cfg_wr_i && cfg_idx_i == IDX_SMBASE && (cfg_be_i[1:0] != 2'b00);
  assign pm_en_wr    = cfg_wr_i && cfg_idx_i == IDX_PMEN   && cfg_be_i[1];
  assign smb_en_wr   = cfg_wr_i && cfg_idx_i == IDX_SMEN   && cfg_be_i[2];
  assign pin_wr      = cfg_wr_i && cfg_idx_i == IDX_INTPIN && cfg_be_i[1];

  logic unused_lane3;
  assign unused_lane3 = ^{cfg_wdata_i[31:24], cfg_be_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= INT_PIN_RST;
    else if (pin_wr) pin_q <= cfg_wdata_i[15:8];
  end

  pm_base_win #(.ALIGN(PM_ALIGN), .EN_W(PM_EN_W), .EN_BIT(PM_EN_BIT)) u_pm_win (
    .clk_i, .rst_ni,
    .base_wr_i(pm_base_wr), .base_be_i(cfg_be_i[1:0]), .base_wdata_i(cfg_wdata_i[15:0]),
    .en_wr_i(pm_en_wr), .en_wdata_i(cfg_wdata_i[15:8]),
    .base_rd_o(pm_base_rd), .en_rd_o(pm_en_rd),
    .win_base_o(pm_win_base_o), .win_en_o(pm_win_en_o)
  );

  pm_base_win #(.ALIGN(SMB_ALIGN), .EN_W(SMB_EN_W), .EN_BIT(SMB_EN_BIT)) u_smb_win (
    .clk_i, .rst_ni,
    .base_wr_i(smb_base_wr), .base_be_i(cfg_be_i[1:0]), .base_wdata_i(cfg_wdata_i[15:0]),
    .en_wr_i(smb_en_wr), .en_wdata_i(cfg_wdata_i[19:16]),
    .base_rd_o(smb_base_rd), .en_rd_o(smb_en_rd),
    .win_base_o(smb_win_base_o), .win_en_o(smb_win_en_o)
  );

  logic unused_hi_nibble;
  assign unused_hi_nibble = ^cfg_wdata_i[23:20];

  pm1_event_regs u_evt (
    .clk_i, .rst_ni,
    .wr_sts_i(pm1_wr_i && !pm1_sel_i),
    .wr_en_i(pm1_wr_i && pm1_sel_i),
    .wdata_i(pm1_wdata_i),
    .evt_i,
    .pin_nz_i(pin_q != 8'h00),
    .sts_o(pm1_sts_o), .en_o(pm1_en_o),
    .sci_o, .tmr_run_o
  );

  always_comb begin
    unique case (cfg_idx_i)
      IDX_INTPIN: cfg_rdata_o = {16'h0, pin_q, 8'h0};
      IDX_PMEN:   cfg_rdata_o = {16'h0, pm_en_rd, 8'h0};
      IDX_PMBASE: cfg_rdata_o = {16'h0, pm_base_rd};
      IDX_SMBASE: cfg_rdata_o = {16'h0, smb_base_rd};
      IDX_SMEN:   cfg_rdata_o = {12'h0, smb_en_rd, 16'h0};
      default:    cfg_rdata_o = 32'h0;
    endcase
  end

  // R10: writes to other indices leave both base readbacks unchanged
  assert_other_idx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_base_wr && !smb_base_wr) |=> ($stable(pm_base_rd) && $stable(smb_base_rd)));
endmodule

// File: tb/tb_pm_cfg_sci_top.sv
module tb_pm_cfg_sci_top;
  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pm1_wr = 1'b0, pm1_sel = 1'b0;
  logic [15:0] pm1_wdata = '0, evt = '0;
  logic [15:0] sts, en, pm_wb, smb_wb;
  logic        pm_we, smb_we, sci, trun;

  always #(TCK/2) clk = ~clk;

  pm_cfg_sci_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .pm1_wr_i(pm1_wr), .pm1_sel_i(pm1_sel), .pm1_wdata_i(pm1_wdata), .evt_i(evt),
    .pm1_sts_o(sts), .pm1_en_o(en), .pm_win_base_o(pm_wb), .pm_win_en_o(pm_we),
    .smb_win_base_o(smb_wb), .smb_win_en_o(smb_we), .sci_o(sci), .tmr_run_o(trun)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_pmb, m_smb, m_sts, m_en, m_pwb, m_swb;
  logic [7:0]  m_e41, m_pin;
  logic [3:0]  m_d2;
  logic        m_pwe, m_swe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge16(input logic [15:0] old, input logic [1:0] be,
                                          input logic [15:0] d, input logic [15:0] msk);
    logic [15:0] r = old;
    if (be[0]) r[7:0] = d[7:0];
    if (be[1]) r[15:8] = d[15:8];
    return (r & msk) | 16'h1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] i);
    case (i)
      6'h0F: return {16'h0, m_pin, 8'h0};
      6'h10: return {16'h0, m_e41, 8'h0};
      6'h12: return {16'h0, m_pmb};
      6'h24: return {16'h0, m_smb};
      6'h34: return {12'h0, m_d2, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_sci();
    return (m_pin != 0) && ((m_sts & m_en & 16'h0521) != 0);
  endfunction

  task automatic model_reset();
    m_pmb = 16'h1; m_smb = 16'h1; m_sts = 0; m_en = 0; m_pwb = 0; m_swb = 0;
    m_e41 = 0; m_pin = 8'h01; m_d2 = 0; m_pwe = 0; m_swe = 0;
  endtask

  task automatic check_all();
    logic [5:0] ids [6] = '{6'h0F, 6'h10, 6'h12, 6'h24, 6'h34, 6'h3F};
    chk("R3 pm_win_en", {31'h0, pm_we}, {31'h0, m_pwe});
    chk("R3 pm_win_base", {16'h0, pm_wb}, {16'h0, m_pwb});
    chk("R4 smb_win_en", {31'h0, smb_we}, {31'h0, m_swe});
    chk("R4 smb_win_base", {16'h0, smb_wb}, {16'h0, m_swb});
    chk("R6 status", {16'h0, sts}, {16'h0, m_sts});
    chk("R7 enable", {16'h0, en}, {16'h0, m_en});
    chk("R8 sci", {31'h0, sci}, {31'h0, exp_sci()});
    chk("R9 tmr_run", {31'h0, trun}, {31'h0, m_en[0] & ~m_sts[0]});
    for (int k = 0; k < 6; k++) begin
      cfg_idx = ids[k];
      #1;
      chk("R10 cfg readback", cfg_rdata, exp_rd(ids[k]));
    end
  endtask

  task automatic step(input logic w, input logic [5:0] i, input logic [3:0] b,
                      input logic [31:0] d, input logic pw, input logic ps,
                      input logic [15:0] pd, input logic [15:0] ev);
    @(negedge clk);
    cfg_wr = w; cfg_idx = i; cfg_be = b; cfg_wdata = d;
    pm1_wr = pw; pm1_sel = ps; pm1_wdata = pd; evt = ev;
    @(negedge clk);
    cfg_wr = 0; pm1_wr = 0; evt = 0;
    if (w) begin
      if (i == 6'h12) m_pmb = merge16(m_pmb, b[1:0], d[15:0], 16'hFF80);
      if (i == 6'h24) m_smb = merge16(m_smb, b[1:0], d[15:0], 16'hFFF0);
      if (i == 6'h10 && b[1]) begin
        m_e41 = d[15:8]; m_pwe = d[15]; m_pwb = m_pmb & 16'hFFFE;
      end
      if (i == 6'h34 && b[2]) begin
        m_d2 = d[19:16]; m_swe = d[16]; m_swb = m_smb & 16'hFFFE;
      end
      if (i == 6'h0F && b[1]) m_pin = d[15:8];
    end
    if (pw && ps) m_en = pd;
    m_sts = (m_sts & ~((pw && !ps) ? pd : 16'h0)) | ev;
    check_all();
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check_all();
    cfg_idx = 6'h12; #1; chk("R5 pm base reset", cfg_rdata, 32'h1);
    cfg_idx = 6'h24; #1; chk("R5 smb base reset", cfg_rdata, 32'h1);

    // R1: full write masks, window still old (R3)
    step(1, 6'h12, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cfg_idx = 6'h12; #1; chk("R1 pm base mask", cfg_rdata, 32'h0000_FF81);
    chk("R3 no move on base write", {16'h0, pm_wb}, 32'h0);
    // R3: enable byte
    step(1, 6'h10, 4'h2, 32'h0000_8000, 0, 0, 0, 0);
    chk("R3 pm window on", {15'h0, pm_we, pm_wb}, 32'h0001_FF80);
    // R10: lane 0 only on 0x40 does nothing
    step(1, 6'h10, 4'h1, 32'h0000_00FF, 0, 0, 0, 0);
    step(1, 6'h12, 4'h1, 32'h0000_0000, 0, 0, 0, 0);
    cfg_idx = 6'h12; #1; chk("R10 lane keep", cfg_rdata, 32'h0000_FF01);
    chk("R3 window hold", {16'h0, pm_wb}, 32'h0000_FF80);
    // R2/R4
    step(1, 6'h24, 4'h3, 32'h0000_FFFF, 0, 0, 0, 0);
    cfg_idx = 6'h24; #1; chk("R2 smb base mask", cfg_rdata, 32'h0000_FFF1);
    step(1, 6'h34, 4'h4, 32'h00FF_0000, 0, 0, 0, 0);
    cfg_idx = 6'h34; #1; chk("R4 truncate", cfg_rdata, 32'h000F_0000);
    chk("R4 smb window on", {15'h0, smb_we, smb_wb}, 32'h0001_FFF0);
    // R8: non-SCI bit
    step(0, 0, 0, 0, 1, 1, 16'hFFFF, 16'h0002);
    chk("R8 bit1 no sci", {31'h0, sci}, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, 16'h0100);
    chk("R8 power button sci", {31'h0, sci}, 32'h1);
    step(1, 6'h0F, 4'h2, 32'h0, 0, 0, 0, 0);
    chk("R8 pin zero gate", {31'h0, sci}, 32'h0);
    step(1, 6'h0F, 4'h2, 32'h0000_0100, 0, 0, 0, 0);
    // R6: event beats clear
    step(0, 0, 0, 0, 1, 0, 16'h0100, 16'h0100);
    chk("R6 event wins", {31'h0, sts[8]}, 32'h1);
    step(0, 0, 0, 0, 1, 0, 16'hFFFF, 0);
    chk("R6 w1c all", {16'h0, sts}, 32'h0);
    // R9
    chk("R9 run armed", {31'h0, trun}, 32'h1);
    step(0, 0, 0, 0, 0, 0, 0, 16'h0001);
    chk("R9 run stops", {31'h0, trun}, 32'h0);
    chk("R8 timer sci", {31'h0, sci}, 32'h1);

    // random
    for (int n = 0; n < 600; n++) begin
      logic [5:0] ids [6] = '{6'h0F, 6'h10, 6'h12, 6'h24, 6'h34, 6'h00};
      logic [5:0] ri = ($urandom % 8 == 0) ? 6'($urandom) : ids[$urandom % 6];
      logic [15:0] ev = ($urandom % 3 == 0) ? (16'($urandom) & 16'($urandom)) : 16'h0;
      step($urandom % 2 == 0, ri, 4'($urandom), $urandom,
           $urandom % 3 == 0, 1'($urandom), 16'($urandom), ev);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule